// File: doc/BRIEF.md
# Fully Associative Address Translation Buffer with Page Protection

This block translates virtual addresses into physical addresses through a small, fully associative cache of page mappings. A virtual address is split into a page number (upper bits) and a byte offset (lower bits). The page number is compared against every stored tag in the same cycle. On a match, the block returns the physical address. That address is the stored frame number placed above the offset, which passes through unchanged. The block also reports whether the access breaks the page's protection.

When no stored tag matches, the block stalls and raises a miss request to an external page-table walker. The request carries the page number and the page-table base value that was captured when the request was accepted. The walker's reply (frame number, read-only flag, present flag) is written into a victim slot. The held lookup is then replayed against the updated table. A flush input empties the whole buffer in one cycle, for use when the address space changes on a context switch.

Top module: `va_xlate_tlb`

## Requirements
- R1: The virtual address is 32 bits wide. Bits [11:0] are the offset and bits [31:12] are the page number. A fault-free hit returns the 32-bit physical address {frame[19:0], offset[11:0]}.
- R2: A lookup compares the page number against all occupied entries at once. On a hit, `resp_valid` is high for exactly one cycle, in the cycle after the request is accepted, and no miss request is raised.
- R3: A write that hits an entry with the read-only flag set returns fault code 2 and physical address 0. A read of the same entry returns fault code 0.
- R4: A hit on an entry whose present flag is clear returns fault code 1 and physical address 0. This code takes priority over code 2.
- R5: When no occupied entry matches, `miss_valid` rises the cycle after the lookup cycle. It stays high, with `miss_vpn` and `miss_ptbase` held stable, until a refill arrives. `miss_ptbase` is the value `ptbase` had when the request was accepted. `req_ready` is high only while the block is idle.
- R6: A refill (`fill_valid` while `miss_valid` is high) is written at that edge. The held lookup is replayed in the next cycle, so the response appears one cycle after the refill.
- R7: The refill target is the lowest-index unoccupied entry. When every entry is occupied, the target is a round-robin pointer. The pointer starts at 0 and advances by one (wrapping at the entry count) each time it is used.
- R8: A one-cycle `flush` marks every entry unoccupied, so later lookups of earlier pages miss. The round-robin pointer is unchanged.
- R9: `fill_valid` is ignored unless a miss request is outstanding.
- R10: After reset the buffer is empty and idle: `req_ready`=1, `resp_valid`=0, `miss_valid`=0, and the round-robin pointer is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Invalidate all entries |
| ptbase | input | 32 | Current page-table base value |
| req_valid | input | 1 | Translation request |
| req_ready | output | 1 | Block is idle and accepts a request |
| req_vaddr | input | 32 | Virtual address to translate |
| req_write | input | 1 | Access is a write |
| resp_valid | output | 1 | Translation result valid |
| resp_paddr | output | 32 | Physical address (0 on fault) |
| resp_fault | output | 2 | 0 none, 1 not present, 2 write to read-only |
| miss_valid | output | 1 | Miss request to the walker |
| miss_vpn | output | 20 | Page number to walk |
| miss_ptbase | output | 32 | Page-table base for the walk |
| fill_valid | input | 1 | Walker reply valid |
| fill_frame | input | 20 | Frame number from the walker |
| fill_ro | input | 1 | Page is read-only |
| fill_present | input | 1 | Page is present in the address space |

## Verification
Repeated reads of one page show the difference between a cold miss and a warm hit, both by latency and by the number of miss cycles. Reads and writes to pages with different flag combinations show the clean path, the read-only fault and the not-present fault, including the case where both faults apply. A delayed refill, with the base value changed during the wait, shows that the miss request is held and that the base was captured at acceptance. Filling every slot and then touching new and just-evicted pages shows the lowest-free choice and the round-robin eviction order. A stray refill while idle and a flush show that table contents change only when they should.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

  typedef enum logic [1:0] {
    FLT_NONE   = 2'd0,
    FLT_ABSENT = 2'd1,
    FLT_RDONLY = 2'd2
  } flt_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOOK = 2'd1,
    ST_WAIT = 2'd2
  } tst_e;

endpackage

// File: rtl/tlb_cam.sv
module tlb_cam #(
  parameter int ENTRIES = 32,
  parameter int KEY_W   = 20,
  parameter int VAL_W   = 20,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               flush,
  input  logic [KEY_W-1:0]   key,
  input  logic               wr_en,
  input  logic [IDX_W-1:0]   wr_idx,
  input  logic [KEY_W-1:0]   wr_key,
  input  logic [VAL_W-1:0]   wr_val,
  input  logic               wr_ro,
  input  logic               wr_pres,
  output logic               hit,
  output logic [VAL_W-1:0]   hit_val,
  output logic               hit_ro,
  output logic               hit_pres,
  output logic [ENTRIES-1:0] occ_vec
);

  logic [KEY_W-1:0]   tag_q  [ENTRIES];
  logic [VAL_W-1:0]   val_q  [ENTRIES];
  logic [ENTRIES-1:0] ro_q;
  logic [ENTRIES-1:0] pres_q;
  logic [ENTRIES-1:0] occ_q;
  logic [ENTRIES-1:0] occ_d;
  logic [ENTRIES-1:0] match;

  // Occupancy: flush clears everything, a refill in the same cycle still lands
  always_comb begin
    occ_d = flush ? '0 : occ_q;
    if (wr_en) occ_d[wr_idx] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) occ_q <= '0;
    else        occ_q <= occ_d;
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_q[wr_idx]  <= wr_key;
      val_q[wr_idx]  <= wr_val;
      ro_q[wr_idx]   <= wr_ro;
      pres_q[wr_idx] <= wr_pres;
    end
  end

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign match[g] = occ_q[g] && (tag_q[g] == key);
  end

  always_comb begin
    hit_val  = '0;
    hit_ro   = 1'b0;
    hit_pres = 1'b0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (match[i]) begin
        hit_val  = hit_val | val_q[i];
        hit_ro   = hit_ro | ro_q[i];
        hit_pres = hit_pres | pres_q[i];
      end
    end
  end

  assign hit     = |match;
  assign occ_vec = occ_q;

  AST_ONE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(match)); // R2
  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    flush && !wr_en |=> occ_vec == '0); // R8

endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
  parameter int ENTRIES = 32,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ENTRIES-1:0] occ_vec,
  input  logic               take,
  output logic [IDX_W-1:0]   victim_idx
);

  localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

  logic             have_free;
  logic [IDX_W-1:0] free_idx;
  logic [IDX_W-1:0] rr_q;
  logic             rr_used;

  // Lowest-index free slot: scan downward so the smallest index wins
  always_comb begin
    have_free = 1'b0;
    free_idx  = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!occ_vec[i]) begin
        have_free = 1'b1;
        free_idx  = IDX_W'(i);
      end
    end
  end

  assign victim_idx = have_free ? free_idx : rr_q;
  assign rr_used    = take && !have_free;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rr_q <= '0;
    else if (rr_used) rr_q <= (rr_q == LAST) ? '0 : rr_q + 1'b1;
  end

  AST_VICTIM_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    take && !(&occ_vec) |-> !occ_vec[victim_idx]); // R7
  AST_RR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> $stable(rr_q)); // R7

endmodule

// File: rtl/tlb_ctrl.sv
module tlb_ctrl
  import tlb_pkg::*;
#(
  parameter int VPN_W = 20,
  parameter int OFF_W = 12,
  parameter int PTB_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [VPN_W-1:0] req_vpn,
  input  logic [OFF_W-1:0] req_off,
  input  logic             req_write,
  input  logic [PTB_W-1:0] ptbase,
  input  logic             fill_valid,
  input  logic             look_hit,
  input  logic             look_ro,
  input  logic             look_pres,
  output logic             req_ready,
  output logic [VPN_W-1:0] pend_vpn,
  output logic [OFF_W-1:0] pend_off,
  output logic             resp_valid,
  output logic [1:0]       resp_fault,
  output logic             miss_valid,
  output logic [PTB_W-1:0] miss_ptbase,
  output logic             fill_take
);

  tst_e             st_q, st_d;
  logic             wr_q;
  logic [VPN_W-1:0] vpn_q;
  logic [OFF_W-1:0] off_q;
  logic [PTB_W-1:0] base_q;
  flt_e             flt;

  // Named events for the checks
  logic ev_accept, ev_hit, ev_miss, ev_refill;

  assign ev_accept = (st_q == ST_IDLE) && req_valid;
  assign ev_hit    = (st_q == ST_LOOK) && look_hit;
  assign ev_miss   = (st_q == ST_LOOK) && !look_hit;
  assign ev_refill = (st_q == ST_WAIT) && fill_valid;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (ev_accept) st_d = ST_LOOK;
      ST_LOOK: st_d = ev_hit ? ST_IDLE : ST_WAIT;
      ST_WAIT: if (ev_refill) st_d = ST_LOOK;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  always_ff @(posedge clk) begin
    if (ev_accept) begin
      vpn_q  <= req_vpn;
      off_q  <= req_off;
      wr_q   <= req_write;
      base_q <= ptbase;
    end
  end

  // Fault priority: a missing page outranks a write to a read-only page
  always_comb begin
    if (!look_pres)          flt = FLT_ABSENT;
    else if (wr_q && look_ro) flt = FLT_RDONLY;
    else                     flt = FLT_NONE;
  end

  assign req_ready   = (st_q == ST_IDLE);
  assign pend_vpn    = vpn_q;
  assign pend_off    = off_q;
  assign resp_valid  = ev_hit;
  assign resp_fault  = ev_hit ? flt : FLT_NONE;
  assign miss_valid  = (st_q == ST_WAIT);
  assign miss_ptbase = base_q;
  assign fill_take   = ev_refill;

  AST_RESP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |=> !resp_valid && req_ready); // R2
  AST_MISS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    miss_valid && !fill_valid |=> miss_valid && $stable(pend_vpn) && $stable(miss_ptbase)); // R5
  AST_MISS_AFTER_LOOK: assert property (@(posedge clk) disable iff (!rst_n)
    ev_miss |=> miss_valid && !req_ready); // R5
  AST_RO_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid && resp_fault == 2'd2 |-> wr_q); // R3

endmodule

// File: rtl/va_xlate_tlb.sv
module va_xlate_tlb
  import tlb_pkg::*;
#(
  parameter int VA_W      = 32,
  parameter int PAGE_BITS = 12,
  parameter int FRAME_W   = 20,
  parameter int ENTRIES   = 32,
  parameter int PTB_W     = 32,
  localparam int VPN_W    = VA_W - PAGE_BITS,
  localparam int PA_W     = FRAME_W + PAGE_BITS,
  localparam int IDX_W    = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               flush,
  input  logic [PTB_W-1:0]   ptbase,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [VA_W-1:0]    req_vaddr,
  input  logic               req_write,
  output logic               resp_valid,
  output logic [PA_W-1:0]    resp_paddr,
  output logic [1:0]         resp_fault,
  output logic               miss_valid,
  output logic [VPN_W-1:0]   miss_vpn,
  output logic [PTB_W-1:0]   miss_ptbase,
  input  logic               fill_valid,
  input  logic [FRAME_W-1:0] fill_frame,
  input  logic               fill_ro,
  input  logic               fill_present
);

  function automatic logic [VPN_W-1:0] page_of(input logic [VA_W-1:0] va);
    return va[VA_W-1:PAGE_BITS];
  endfunction

  function automatic logic [PAGE_BITS-1:0] offset_of(input logic [VA_W-1:0] va);
    return va[PAGE_BITS-1:0];
  endfunction

  function automatic logic [PA_W-1:0] compose_pa(input logic [FRAME_W-1:0] fr,
                                                 input logic [PAGE_BITS-1:0] off);
    return {fr, off};
  endfunction

  logic [VPN_W-1:0]     pend_vpn;
  logic [PAGE_BITS-1:0] pend_off;
  logic                 cam_hit, cam_ro, cam_pres;
  logic [FRAME_W-1:0]   cam_frame;
  logic [ENTRIES-1:0]   cam_occ;
  logic                 fill_take;
  logic [IDX_W-1:0]     victim_idx;

  tlb_ctrl #(
    .VPN_W(VPN_W), .OFF_W(PAGE_BITS), .PTB_W(PTB_W)
  ) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_vpn    (page_of(req_vaddr)),
    .req_off    (offset_of(req_vaddr)),
    .req_write  (req_write),
    .ptbase     (ptbase),
    .fill_valid (fill_valid),
    .look_hit   (cam_hit),
    .look_ro    (cam_ro),
    .look_pres  (cam_pres),
    .req_ready  (req_ready),
    .pend_vpn   (pend_vpn),
    .pend_off   (pend_off),
    .resp_valid (resp_valid),
    .resp_fault (resp_fault),
    .miss_valid (miss_valid),
    .miss_ptbase(miss_ptbase),
    .fill_take  (fill_take)
  );

  tlb_cam #(
    .ENTRIES(ENTRIES), .KEY_W(VPN_W), .VAL_W(FRAME_W)
  ) u_cam (
    .clk     (clk),
    .rst_n   (rst_n),
    .flush   (flush),
    .key     (pend_vpn),
    .wr_en   (fill_take),
    .wr_idx  (victim_idx),
    .wr_key  (pend_vpn),
    .wr_val  (fill_frame),
    .wr_ro   (fill_ro),
    .wr_pres (fill_present),
    .hit     (cam_hit),
    .hit_val (cam_frame),
    .hit_ro  (cam_ro),
    .hit_pres(cam_pres),
    .occ_vec (cam_occ)
  );

  tlb_victim #(
    .ENTRIES(ENTRIES)
  ) u_victim (
    .clk       (clk),
    .rst_n     (rst_n),
    .occ_vec   (cam_occ),
    .take      (fill_take),
    .victim_idx(victim_idx)
  );

  assign miss_vpn   = pend_vpn;
  assign resp_paddr = (resp_valid && resp_fault == FLT_NONE)
                      ? compose_pa(cam_frame, pend_off) : '0;

  AST_REPLAY_HITS: assert property (@(posedge clk) disable iff (!rst_n)
    miss_valid && fill_valid |=> resp_valid); // R6
  AST_STRAY_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    fill_valid && !miss_valid && !flush |=> $stable(cam_occ)); // R9
  AST_RO_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid && !cam_ro |-> resp_fault != 2'd2); // R3
  AST_FAULT_PA_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid && !cam_pres |-> resp_fault == 2'd1 && resp_paddr == '0); // R4

endmodule

// File: tb/sim_va_xlate_tlb.sv
module sim_va_xlate_tlb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        flush = 1'b0;
  logic [31:0] ptbase = 32'h0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_vaddr = 32'h0;
  logic        req_write = 1'b0;
  logic        resp_valid;
  logic [31:0] resp_paddr;
  logic [1:0]  resp_fault;
  logic        miss_valid;
  logic [19:0] miss_vpn;
  logic [31:0] miss_ptbase;
  logic        fill_valid = 1'b0;
  logic [19:0] fill_frame = 20'h0;
  logic        fill_ro = 1'b0;
  logic        fill_present = 1'b0;

  always #4 clk = ~clk;

  va_xlate_tlb u0 (
    .clk(clk), .rst_n(rst_n), .flush(flush), .ptbase(ptbase),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
    .req_write(req_write), .resp_valid(resp_valid), .resp_paddr(resp_paddr),
    .resp_fault(resp_fault), .miss_valid(miss_valid), .miss_vpn(miss_vpn),
    .miss_ptbase(miss_ptbase), .fill_valid(fill_valid), .fill_frame(fill_frame),
    .fill_ro(fill_ro), .fill_present(fill_present)
  );

  int nchk = 0;
  int nfail = 0;
  int cyc = 0;
  bit cmp_on = 1'b0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s act=%0h exp=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Page table held by the bench walker
  function automatic logic [19:0] pt_frame(input logic [19:0] v);
    return v ^ 20'hA5A5A;
  endfunction
  function automatic bit pt_ro(input logic [19:0] v);
    return v[4];
  endfunction
  function automatic bit pt_pres(input logic [19:0] v);
    return v[3:0] != 4'hF;
  endfunction

  // ---------------- behavioural reference model ----------------
  logic [19:0] m_tag [32];
  logic [19:0] m_frm [32];
  bit          m_occ [32];
  bit          m_pres[32];
  bit          m_ro  [32];
  int          m_st = 0;
  int          m_rr = 0;
  logic [19:0] p_vpn = 20'h0;
  logic [11:0] p_off = 12'h0;
  bit          p_wr = 1'b0;
  logic [31:0] p_base = 32'h0;

  function automatic int m_find();
    for (int i = 0; i < 32; i++)
      if (m_occ[i] && m_tag[i] == p_vpn) return i;
    return -1;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0;
      m_rr = 0;
      for (int i = 0; i < 32; i++) m_occ[i] = 1'b0;
    end else begin
      int h;
      int v;
      bit wv;
      h = m_find();
      v = -1;
      wv = 1'b0;
      case (m_st)
        0: if (req_valid) begin
             p_vpn = req_vaddr[31:12];
             p_off = req_vaddr[11:0];
             p_wr = req_write;
             p_base = ptbase;
             m_st = 1;
           end
        1: m_st = (h >= 0) ? 0 : 2;
        default: if (fill_valid) begin
             for (int i = 0; i < 32; i++)
               if (!m_occ[i] && v < 0) v = i;
             if (v < 0) begin
               v = m_rr;
               m_rr = (m_rr + 1) % 32;
             end
             wv = 1'b1;
             m_st = 1;
           end
      endcase
      if (flush)
        for (int i = 0; i < 32; i++) m_occ[i] = 1'b0;
      if (wv) begin
        m_tag[v] = p_vpn;
        m_frm[v] = fill_frame;
        m_pres[v] = fill_present;
        m_ro[v] = fill_ro;
        m_occ[v] = 1'b1;
      end
    end
  end

  // Per-cycle comparison against the model
  always @(negedge clk) begin
    if (cmp_on) begin
      int h;
      int ef;
      logic [31:0] epa;
      h = m_find();
      chk(req_ready == (m_st == 0), "R5 ready", 64'(req_ready), 64'(m_st == 0));
      chk(resp_valid == (m_st == 1 && h >= 0), "R2 resp_valid",
          64'(resp_valid), 64'(m_st == 1 && h >= 0));
      if (m_st == 1 && h >= 0) begin
        ef = !m_pres[h] ? 1 : ((p_wr && m_ro[h]) ? 2 : 0);
        epa = (ef == 0) ? {m_frm[h], p_off} : 32'h0;
        chk(resp_fault == 2'(ef), (ef == 1) ? "R4 fault" : "R3 fault",
            64'(resp_fault), 64'(ef));
        chk(resp_paddr == epa, "R1 paddr", 64'(resp_paddr), 64'(epa));
      end
      chk(miss_valid == (m_st == 2), "R5 miss_valid", 64'(miss_valid), 64'(m_st == 2));
      if (m_st == 2) begin
        chk(miss_vpn == p_vpn, "R5 miss_vpn", 64'(miss_vpn), 64'(p_vpn));
        chk(miss_ptbase == p_base, "R5 miss_ptbase", 64'(miss_ptbase), 64'(p_base));
      end
    end
  end

  // ---------------- stimulus ----------------
  logic [31:0] got_pa;
  logic [1:0]  got_flt;
  logic [31:0] base_seen;
  int          nmiss;
  int          lat;
  int          fill_delay = 0;
  bit          wiggle = 1'b0;

  task automatic xlate(input logic [31:0] va, input bit wr);
    bit done;
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1;
    req_vaddr = va;
    req_write = wr;
    @(negedge clk);
    req_valid = 1'b0;
    nmiss = 0;
    lat = 1;
    done = 1'b0;
    while (!done) begin
      if (resp_valid) begin
        got_pa = resp_paddr;
        got_flt = resp_fault;
        done = 1'b1;
      end else begin
        if (miss_valid) begin
          if (nmiss == 0) begin
            base_seen = miss_ptbase;
            if (wiggle) ptbase = ptbase ^ 32'hFFFF_0000;
          end
          nmiss++;
          if (nmiss > fill_delay) begin
            fill_valid = 1'b1;
            fill_frame = pt_frame(miss_vpn);
            fill_ro = pt_ro(miss_vpn);
            fill_present = pt_pres(miss_vpn);
          end
        end
        @(negedge clk);
        fill_valid = 1'b0;
        lat++;
      end
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 60000) begin
      nfail++;
      $display("FAIL watchdog all-requirements act=%0d exp=<60000 cycles", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    int tot;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10: reset state
    chk(req_ready == 1'b1, "R10 ready", 64'(req_ready), 64'd1);
    chk(resp_valid == 1'b0, "R10 resp_valid", 64'(resp_valid), 64'd0);
    chk(miss_valid == 1'b0, "R10 miss_valid", 64'(miss_valid), 64'd0);
    cmp_on = 1'b1;

    // Cold read: miss, refill, replay (R1, R5, R6)
    ptbase = 32'h0004_0000;
    xlate(32'h1234_5678, 1'b0);
    chk(nmiss == 1, "R5 cold miss count", 64'(nmiss), 64'd1);
    chk(lat == 3, "R6 refill replay latency", 64'(lat), 64'd3);
    chk(got_pa == 32'hB791_F678, "R1 cold paddr", 64'(got_pa), 64'hB791F678);
    chk(base_seen == 32'h0004_0000, "R5 base", 64'(base_seen), 64'h40000);

    // Warm read and write of the same page (R2)
    xlate(32'h1234_5ABC, 1'b0);
    chk(nmiss == 0 && lat == 1, "R2 warm hit", 64'(lat + 16 * nmiss), 64'd1);
    chk(got_pa == 32'hB791_FABC, "R1 warm paddr", 64'(got_pa), 64'hB791FABC);
    xlate(32'h1234_5001, 1'b1);
    chk(got_flt == 2'd0, "R3 write to writable", 64'(got_flt), 64'd0);

    // Read-only page (R3)
    xlate(32'h0001_0004, 1'b1);
    chk(got_flt == 2'd2 && got_pa == 32'h0, "R3 write to read-only",
        {30'h0, got_flt, got_pa}, 64'h2_0000_0000);
    xlate(32'h0001_0004, 1'b0);
    chk(got_flt == 2'd0 && got_pa == 32'hA5A4_A004, "R3 read of read-only",
        {30'h0, got_flt, got_pa}, 64'hA5A4A004);

    // Absent pages, including priority over read-only (R4)
    xlate(32'h0002_F010, 1'b0);
    chk(got_flt == 2'd1 && got_pa == 32'h0, "R4 absent read",
        {30'h0, got_flt, got_pa}, 64'h1_0000_0000);
    xlate(32'h0001_F010, 1'b1);
    chk(got_flt == 2'd1, "R4 absent over read-only", 64'(got_flt), 64'd1);

    // Delayed refill with base changing during the wait (R5, R6)
    fill_delay = 4;
    wiggle = 1'b1;
    ptbase = 32'h0000_1000;
    xlate(32'h0ABC_D123, 1'b0);
    chk(nmiss == 5, "R5 stall held", 64'(nmiss), 64'd5);
    chk(base_seen == 32'h0000_1000, "R5 base captured at accept",
        64'(base_seen), 64'h1000);
    chk(lat == 7, "R6 replay after delayed refill", 64'(lat), 64'd7);
    fill_delay = 0;
    wiggle = 1'b0;

    // Stray refill while idle is ignored (R9)
    while (!req_ready) @(negedge clk);
    fill_valid = 1'b1;
    fill_frame = 20'hFFFFF;
    fill_ro = 1'b1;
    fill_present = 1'b0;
    @(negedge clk);
    fill_valid = 1'b0;
    xlate(32'h0ABC_D123, 1'b0);
    chk(nmiss == 0 && got_pa == {pt_frame(20'h0ABCD), 12'h123}, "R9 stray fill ignored",
        {nmiss[31:0], got_pa}, {32'd0, pt_frame(20'h0ABCD), 12'h123});

    // Flush (R8)
    @(negedge clk);
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
    xlate(32'h1234_5678, 1'b0);
    chk(nmiss == 1, "R8 miss after flush", 64'(nmiss), 64'd1);

    // Fill all slots, then evict in round-robin order (R7)
    @(negedge clk);
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
    for (int i = 0; i < 32; i++) xlate({20'h00100 + 20'(i), 12'h040}, 1'b0);
    tot = 0;
    for (int i = 0; i < 32; i++) begin
      xlate({20'h00100 + 20'(i), 12'h080}, 1'b0);
      tot += nmiss;
    end
    chk(tot == 0, "R7 free slots filled first", 64'(tot), 64'd0);
    xlate(32'h0020_0000, 1'b0);
    chk(nmiss == 1, "R7 full table miss", 64'(nmiss), 64'd1);
    xlate(32'h0010_1000, 1'b0);
    chk(nmiss == 0, "R7 slot 1 kept", 64'(nmiss), 64'd0);
    xlate(32'h0010_0000, 1'b0);
    chk(nmiss == 1, "R7 slot 0 evicted first", 64'(nmiss), 64'd1);
    xlate(32'h0010_1000, 1'b0);
    chk(nmiss == 1, "R7 slot 1 evicted next", 64'(nmiss), 64'd1);
    xlate(32'h0010_3000, 1'b0);
    chk(nmiss == 0, "R7 slot 3 kept", 64'(nmiss), 64'd0);

    repeat (3) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

endmodule